// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It handles the one data dependence that forwarding cannot cover: an instruction in decode that reads a register which a load, now in the execute stage, has not yet brought back from memory. When that case appears, the unit holds the program counter and the fetch/decode pipeline register for one cycle, so the same instruction is fetched again and decoded again. It also tells the decode stage to load an all-zero control bundle into the decode/execute register in place of the real one.

The zeroed bundle moves down the pipe as a bubble. It writes no register and no memory. One cycle later the load has reached the memory stage, so the ordinary forwarding path can supply the loaded value and no further cycle is lost. The stall decision is purely combinational on the current pipeline register fields. The clock and reset ports only sample the built-in timing checks.

Top module: `load_use_stall`

## Requirements
- R1: When the execute-stage memory-read flag is 1 and the execute-stage destination (rt) field equals the decode-stage rs field, a stall is raised.
- R2: When the execute-stage memory-read flag is 1 and the execute-stage destination field equals the decode-stage rt field, a stall is raised.
- R3: During a stall, `pc_we` = 0, `ifid_we` = 0 and `ctrl_zero` = 1, where 1 selects the all-zero control bundle. With no stall the outputs are `pc_we` = 1, `ifid_we` = 1, `ctrl_zero` = 0, and these are also the values right after reset.
- R4: With the memory-read flag at 0, a match between the register fields raises no stall, because forwarding covers that case.
- R5: With parameter `SKIP_R0` = 1 (default), a load whose destination field is 0 raises no stall, even if a source field is also 0.
- R6: A load whose destination matches neither source field raises no stall. The same holds for an instruction that uses the load result two slots later.
- R7: Each hazard costs exactly one cycle. In a pipeline that applies the outputs, a stall cycle is never followed by another stall caused by the same load. Instruction i enters the execute stage i+2 clock edges after reset, plus one edge for each stall raised by instructions 0..i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock for the built-in timing checks |
| rst_n | input | 1 | Active-low reset for the timing checks |
| idex_memrd | input | 1 | Memory-read flag held in the decode/execute register |
| idex_rt | input | REG_W | Load destination field held in the decode/execute register |
| ifid_rs | input | REG_W | First source field of the instruction in decode |
| ifid_rt | input | REG_W | Second source field of the instruction in decode |
| pc_we | output | 1 | Program counter write enable (0 holds the PC) |
| ifid_we | output | 1 | Fetch/decode register write enable (0 holds it) |
| ctrl_zero | output | 1 | 1 selects the all-zero control bundle for the decode/execute register |

## Verification
The block holds no state, so a faulty compare or a dropped term shows at the three outputs in the same cycle as the input pattern that exposes it. A missing stall lets the dependent instruction enter execute one edge too early. A spurious stall delays every later instruction by one edge. The bench runs a small pipeline model driven by the outputs, so either fault also appears as a shifted entry time for every instruction after the point of failure.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int REG_W   = 5,
  parameter bit SKIP_R0 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idex_memrd,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ctrl_zero
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dst_live;
  logic hit_rs;
  logic hit_rt;
  logic stall;

  generate
    if (SKIP_R0) begin : g_skip_r0
      assign dst_live = (idex_rt != ZERO_REG);
    end else begin : g_all_regs
      assign dst_live = 1'b1;
    end
  endgenerate

  assign hit_rs = (idex_rt == ifid_rs);
  assign hit_rt = (idex_rt == ifid_rt);
  assign stall  = idex_memrd & dst_live & (hit_rs | hit_rt);

  assign pc_we     = ~stall;
  assign ifid_we   = ~stall;
  assign ctrl_zero = stall;

  AST_RS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_memrd && idex_rt != ZERO_REG && idex_rt == ifid_rs) |-> ctrl_zero); // R1
  AST_RT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_memrd && idex_rt != ZERO_REG && idex_rt == ifid_rt) |-> ctrl_zero); // R2
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |-> (!pc_we && !ifid_we)); // R3
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_memrd |-> (pc_we && ifid_we && !ctrl_zero)); // R4
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |=> !ctrl_zero); // R7

  generate
    if (SKIP_R0) begin : g_r0_check
      AST_R0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == ZERO_REG) |-> !ctrl_zero); // R5
    end
  endgenerate

endmodule

// File: tb/test_load_use_stall.sv
module test_load_use_stall;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  typedef struct packed {
    logic       ld;
    logic [4:0] dst;
    logic [4:0] s1;
    logic [4:0] s2;
  } ins_t;

  typedef struct {
    logic  stall;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  ins_t prog [N];
  int   stalls_upto [N];

  int         pc = 0;
  ins_t       m_ifid = '0;
  int         m_ifid_idx = -1;
  ins_t       m_idex = '0;
  int         edges = 0;
  int         checks = 0;
  int         errors = 0;
  int         entered = 0;
  exp_t       sb [$];
  logic       prev_zero = 1'b0;

  logic pc_we, ifid_we, ctrl_zero;

  load_use_stall #(.REG_W(5), .SKIP_R0(1'b1)) i_load_use_stall (
    .clk(clk), .rst_n(rst_n),
    .idex_memrd(m_idex.ld), .idex_rt(m_idex.dst),
    .ifid_rs(m_ifid.s1), .ifid_rt(m_ifid.s2),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero)
  );

  function automatic ins_t mk(logic ld, int dst, int s1, int s2);
    ins_t t;
    t.ld = ld; t.dst = 5'(dst); t.s1 = 5'(s1); t.s2 = 5'(s2);
    return t;
  endfunction

  initial begin
    prog[0]  = mk(1, 1, 2, 0);
    prog[1]  = mk(0, 4, 1, 3);    // R1 rs use
    prog[2]  = mk(1, 5, 6, 0);
    prog[3]  = mk(0, 0, 7, 5);    // R2 rt use
    prog[4]  = mk(1, 0, 8, 0);
    prog[5]  = mk(0, 3, 0, 0);    // R5 load to r0
    prog[6]  = mk(0, 9, 1, 2);
    prog[7]  = mk(0, 6, 9, 9);    // R4 non-load match
    prog[8]  = mk(1, 10, 1, 0);
    prog[9]  = mk(0, 7, 11, 12);  // R6 no match
    prog[10] = mk(0, 8, 10, 0);   // R6 two slots later
    prog[11] = mk(1, 13, 2, 0);
    prog[12] = mk(1, 14, 13, 0);  // load uses load
    prog[13] = mk(0, 15, 14, 14); // both fields
    prog[14] = mk(1, 15, 3, 0);
    prog[15] = mk(0, 2, 4, 6);
    for (int i = 0; i < N; i++) begin
      logic h;
      h = (i > 0) && prog[i-1].ld && prog[i-1].dst != 0 &&
          (prog[i-1].dst == prog[i].s1 || prog[i-1].dst == prog[i].s2);
      stalls_upto[i] = (i > 0 ? stalls_upto[i-1] : 0) + (h ? 1 : 0);
    end
  end

  task automatic push_expected();
    exp_t e;
    logic m1, m2;
    m1 = (m_idex.dst == m_ifid.s1);
    m2 = (m_idex.dst == m_ifid.s2);
    e.stall = m_idex.ld && m_idex.dst != 0 && (m1 || m2);
    if (!m_idex.ld) e.tag = "R4";
    else if (m_idex.dst == 0) e.tag = "R5";
    else if (m1) e.tag = "R1";
    else if (m2) e.tag = "R2";
    else e.tag = "R6";
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ({pc_we, ifid_we, ctrl_zero} !== {~e.stall, ~e.stall, e.stall}) begin
        errors++;
        $display("FAIL %s/R3: outputs pc_we,ifid_we,ctrl_zero=%b%b%b expected %b%b%b",
                 e.tag, pc_we, ifid_we, ctrl_zero, ~e.stall, ~e.stall, e.stall);
      end
      checks++;
      if (prev_zero && ctrl_zero) begin
        errors++;
        $display("FAIL R7: ctrl_zero=1 two cycles in a row, expected 0 after a stall");
      end
      prev_zero = ctrl_zero;
    end
  end

  initial begin
    logic s_stall;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({pc_we, ifid_we, ctrl_zero} !== 3'b110) begin
      errors++;
      $display("FAIL R3: reset outputs %b%b%b expected 110", pc_we, ifid_we, ctrl_zero);
    end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < N + 8; cyc++) begin
      @(negedge clk);
      push_expected();
      s_stall = ctrl_zero;
      @(posedge clk);
      #1;
      edges++;
      if (s_stall) begin
        m_idex = '0;
      end else begin
        m_idex = m_ifid;
        if (m_ifid_idx >= 0 && m_ifid_idx < N) begin
          checks++;
          entered++;
          if (edges != m_ifid_idx + 2 + stalls_upto[m_ifid_idx]) begin
            errors++;
            $display("FAIL R7: instr %0d entered execute at edge %0d expected %0d",
                     m_ifid_idx, edges, m_ifid_idx + 2 + stalls_upto[m_ifid_idx]);
          end
        end
        m_ifid     = (pc < N) ? prog[pc] : '0;
        m_ifid_idx = (pc < N) ? pc : -1;
        pc++;
      end
    end
    @(negedge clk);
    #2;
    checks++;
    if (entered != N) begin
      errors++;
      $display("FAIL R7: %0d instructions entered execute expected %0d", entered, N);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL R7: watchdog expired, actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule